// File: doc/BRIEF.md
# Dual-Core Lockstep Fault Supervisor

This block watches two identical cores that execute one instruction stream in step. On every cycle where both cores commit, it compares their committed results: the register write value, the destination register, the store enable and, when a store is made, the store address and store data. A difference is handled first as a transient upset: the block raises a one-cycle retry request that carries the program counter of the instruction, and both cores re-execute it.

A one-entry tracker remembers the program counter of the last difference and how often it has failed in a row. Once that count climbs above a limit set on an input, the fault is taken as permanent. Both cores are then stalled and the block enters a test mode. It waits for an external test sequence to report one pass bit per core. The block then switches off the core that failed and lets the survivor run alone with comparison disabled. If both pass, it goes back to lockstep. If both fail, it raises a fatal flag and keeps the cores stalled. A sticky status word keeps the outcome until reset.

Top module: `lockstep_supervisor`

## Requirements
- R1: After reset both core enables are 1, the block is in lockstep mode, and retry, hold, test_mode, fatal and status are all 0.
- R2: Results are compared only in lockstep mode on a cycle where a_valid and b_valid are both 1; a commit from one core alone never causes a retry.
- R3: A difference in write data, destination, or store enable, or a difference in store address or store data while the store enable is 1, makes retry 1 for exactly one cycle, starting in the cycle after the commit. retry_pc then equals that commit_pc.
- R4: Commits presented during the cycle that retry is 1 are not compared and cause no further retry.
- R5: The tracker adds one to its count for a difference at the stored program counter. A difference at any other program counter stores the new one and sets the count to 1. When the updated count is greater than perm_limit, the fault is permanent.
- R6: The 4-bit count saturates at 15, so with perm_limit = 15 repeated differences always retry and never escalate.
- R7: A permanent fault gives no retry. From the next cycle it sets hold and test_mode to 1 and status bit 3 to 1. These stay set, with any commits ignored, until test_done is 1.
- R8: On test_done with exactly one pass bit set, the failing core's enable goes to 0. hold and test_mode return to 0. status bit 0 (core A removed) or bit 1 (core B removed) is set.
- R9: With one core enabled, no comparison is made and retry and hold stay 0.
- R10: On test_done with both pass bits set, both enables stay 1, the block returns to lockstep mode and the tracker is cleared, so the next difference counts as 1.
- R11: On test_done with both pass bits clear, fatal and status bit 2 become 1. hold stays 1, test_mode goes to 0, and test_done has no further effect.
- R12: Status bits are sticky and are cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid | input | 1 | Core A commits this cycle |
| a_wdata | input | DATA_W | Core A register write value |
| a_wdst | input | REG_W | Core A destination register |
| a_swe | input | 1 | Core A store enable |
| a_saddr | input | ADDR_W | Core A store address |
| a_sdata | input | DATA_W | Core A store data |
| b_valid | input | 1 | Core B commits this cycle |
| b_wdata | input | DATA_W | Core B register write value |
| b_wdst | input | REG_W | Core B destination register |
| b_swe | input | 1 | Core B store enable |
| b_saddr | input | ADDR_W | Core B store address |
| b_sdata | input | DATA_W | Core B store data |
| commit_pc | input | PC_W | Program counter of the committing instruction |
| perm_limit | input | CNT_W | Repeat count above which a fault is permanent |
| test_done | input | 1 | Test sequence finished, pass bits valid |
| test_pass_a | input | 1 | Core A passed its test |
| test_pass_b | input | 1 | Core B passed its test |
| retry | output | 1 | One-cycle request to re-execute |
| retry_pc | output | PC_W | Program counter to re-execute |
| hold | output | 1 | Stall both cores |
| test_mode | output | 1 | Processor test mode active |
| core_en | output | 2 | Enable for core B (bit 1) and core A (bit 0) |
| fatal | output | 1 | Both cores failed their test |
| status | output | 4 | Sticky: bit 3 permanent fault, bit 2 fatal, bit 1 B removed, bit 0 A removed |

## Verification
The assertions assume that test_done is only meaningful in test mode and that a retry can only follow a cycle where both cores committed. The checker properties on hold, retry and the core enables rely on the pass bits being stable while test_done is 1. The stimulus holds the inputs constant from one falling edge to the next, pulses test_done for a single cycle with the pass bits set in the same cycle, and leaves perm_limit unchanged within each scenario, so the repeat counts it expects follow from the table alone.

// File: rtl/lsv_pkg.sv
package lsv_pkg;

  typedef enum logic [2:0] {
    ST_SYNC  = 3'd0,
    ST_RETRY = 3'd1,
    ST_TEST  = 3'd2,
    ST_SOLO  = 3'd3,
    ST_FATAL = 3'd4
  } lsv_state_e;

  typedef struct packed {
    logic perm;
    logic fatal;
    logic b_gone;
    logic a_gone;
  } lsv_status_t;

endpackage

// File: rtl/lsv_compare.sv
module lsv_compare #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int ADDR_W = 32
) (
  input  logic [DATA_W-1:0] a_wdata,
  input  logic [REG_W-1:0]  a_wdst,
  input  logic              a_swe,
  input  logic [ADDR_W-1:0] a_saddr,
  input  logic [DATA_W-1:0] a_sdata,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic [REG_W-1:0]  b_wdst,
  input  logic              b_swe,
  input  logic [ADDR_W-1:0] b_saddr,
  input  logic [DATA_W-1:0] b_sdata,
  output logic              differ
);

  logic reg_diff;
  logic store_diff;

  always_comb begin
    reg_diff   = (a_wdata != b_wdata) || (a_wdst != b_wdst);
    store_diff = (a_swe != b_swe) ||
                 (a_swe && ((a_saddr != b_saddr) || (a_sdata != b_sdata)));
    differ     = reg_diff || store_diff;
  end

endmodule

// File: rtl/lsv_fault_track.sv
module lsv_fault_track #(
  parameter int PC_W  = 32,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic [PC_W-1:0]  pc,
  input  logic [CNT_W-1:0] limit,
  output logic             perm_hit
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [PC_W-1:0]  trk_pc_q;
  logic [CNT_W-1:0] trk_cnt_q;
  logic             trk_vld_q;

  logic [CNT_W-1:0] cnt_n;
  logic             same_pc;
  logic             ld_en;

  always_comb begin
    same_pc  = trk_vld_q && (trk_pc_q == pc);
    if (same_pc) begin
      cnt_n = (trk_cnt_q == CNT_MAX) ? CNT_MAX : trk_cnt_q + CNT_ONE;
    end else begin
      cnt_n = CNT_ONE;
    end
    perm_hit = upd && (cnt_n > limit);
    ld_en    = upd || clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_pc_q  <= '0;
      trk_cnt_q <= '0;
      trk_vld_q <= 1'b0;
    end else if (ld_en) begin
      if (clr) begin
        trk_pc_q  <= '0;
        trk_cnt_q <= '0;
        trk_vld_q <= 1'b0;
      end else begin
        trk_pc_q  <= pc;
        trk_cnt_q <= cnt_n;
        trk_vld_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lsv_mode_ctrl.sv
module lsv_mode_ctrl
  import lsv_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_valid,
  input  logic            b_valid,
  input  logic            differ,
  input  logic            perm_hit,
  input  logic [PC_W-1:0] pc,
  input  logic            test_done,
  input  logic            pass_a,
  input  logic            pass_b,
  output logic            trk_upd,
  output logic            trk_clr,
  output logic            retry,
  output logic [PC_W-1:0] retry_pc,
  output logic            hold,
  output logic            test_mode,
  output logic [1:0]      core_en,
  output logic            fatal,
  output lsv_status_t     status
);

  lsv_state_e  state_q, state_n;
  logic        retry_q, hold_q, test_q, fatal_q;
  logic        retry_n, hold_n, test_n, fatal_n;
  logic [PC_W-1:0] rpc_q;
  logic [1:0]  en_q, en_n;
  lsv_status_t st_q, st_n;
  logic        cmp_en;
  logic        rpc_en;
  logic        verdict;

  always_comb begin
    cmp_en  = (state_q == ST_SYNC) && a_valid && b_valid;
    trk_upd = cmp_en && differ;
    verdict = (state_q == ST_TEST) && test_done;
    trk_clr = verdict;
    rpc_en  = trk_upd && !perm_hit;
  end

  always_comb begin
    state_n = state_q;
    en_n    = en_q;
    st_n    = st_q;
    unique case (state_q)
      ST_SYNC: begin
        if (trk_upd) begin
          if (perm_hit) begin
            state_n = ST_TEST;
            st_n.perm = 1'b1;
          end else begin
            state_n = ST_RETRY;
          end
        end
      end
      ST_RETRY: state_n = ST_SYNC;
      ST_TEST: begin
        if (test_done) begin
          unique case ({pass_b, pass_a})
            2'b11: state_n = ST_SYNC;
            2'b01: begin
              state_n     = ST_SOLO;
              en_n        = 2'b01;
              st_n.b_gone = 1'b1;
            end
            2'b10: begin
              state_n     = ST_SOLO;
              en_n        = 2'b10;
              st_n.a_gone = 1'b1;
            end
            default: begin
              state_n    = ST_FATAL;
              st_n.fatal = 1'b1;
            end
          endcase
        end
      end
      ST_SOLO:  state_n = ST_SOLO;
      ST_FATAL: state_n = ST_FATAL;
      default:  state_n = ST_SYNC;
    endcase
  end

  always_comb begin
    retry_n = (state_n == ST_RETRY);
    hold_n  = (state_n == ST_TEST) || (state_n == ST_FATAL);
    test_n  = (state_n == ST_TEST);
    fatal_n = (state_n == ST_FATAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SYNC;
      retry_q <= 1'b0;
      hold_q  <= 1'b0;
      test_q  <= 1'b0;
      fatal_q <= 1'b0;
    end else begin
      state_q <= state_n;
      retry_q <= retry_n;
      hold_q  <= hold_n;
      test_q  <= test_n;
      fatal_q <= fatal_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpc_q <= '0;
    end else if (rpc_en) begin
      rpc_q <= pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 2'b11;
      st_q <= '0;
    end else if (verdict || trk_upd) begin
      en_q <= en_n;
      st_q <= st_n;
    end
  end

  always_comb begin
    retry     = retry_q;
    retry_pc  = rpc_q;
    hold      = hold_q;
    test_mode = test_q;
    fatal     = fatal_q;
    core_en   = en_q;
    status    = st_q;
  end

endmodule

// File: rtl/lockstep_supervisor.sv
module lockstep_supervisor
  import lsv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_valid,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic [REG_W-1:0]  a_wdst,
  input  logic              a_swe,
  input  logic [ADDR_W-1:0] a_saddr,
  input  logic [DATA_W-1:0] a_sdata,
  input  logic              b_valid,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic [REG_W-1:0]  b_wdst,
  input  logic              b_swe,
  input  logic [ADDR_W-1:0] b_saddr,
  input  logic [DATA_W-1:0] b_sdata,
  input  logic [PC_W-1:0]   commit_pc,
  input  logic [CNT_W-1:0]  perm_limit,
  input  logic              test_done,
  input  logic              test_pass_a,
  input  logic              test_pass_b,
  output logic              retry,
  output logic [PC_W-1:0]   retry_pc,
  output logic              hold,
  output logic              test_mode,
  output logic [1:0]        core_en,
  output logic              fatal,
  output logic [3:0]        status
);

  logic        differ;
  logic        perm_hit;
  logic        trk_upd;
  logic        trk_clr;
  lsv_status_t st;

  lsv_compare #(
    .DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W)
  ) u_cmp (
    .a_wdata(a_wdata), .a_wdst(a_wdst), .a_swe(a_swe),
    .a_saddr(a_saddr), .a_sdata(a_sdata),
    .b_wdata(b_wdata), .b_wdst(b_wdst), .b_swe(b_swe),
    .b_saddr(b_saddr), .b_sdata(b_sdata),
    .differ(differ)
  );

  lsv_fault_track #(
    .PC_W(PC_W), .CNT_W(CNT_W)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .clr(trk_clr), .upd(trk_upd),
    .pc(commit_pc), .limit(perm_limit), .perm_hit(perm_hit)
  );

  lsv_mode_ctrl #(
    .PC_W(PC_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .b_valid(b_valid),
    .differ(differ), .perm_hit(perm_hit), .pc(commit_pc),
    .test_done(test_done), .pass_a(test_pass_a), .pass_b(test_pass_b),
    .trk_upd(trk_upd), .trk_clr(trk_clr),
    .retry(retry), .retry_pc(retry_pc), .hold(hold),
    .test_mode(test_mode), .core_en(core_en), .fatal(fatal), .status(st)
  );

  assign status = st;

endmodule

// File: rtl/lsv_checker.sv
module lsv_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       a_valid,
  input logic       b_valid,
  input logic       test_done,
  input logic       retry,
  input logic       hold,
  input logic       test_mode,
  input logic [1:0] core_en,
  input logic       fatal,
  input logic [3:0] status
);

  // R3: retry lasts a single cycle
  a_r3_retry_single: assert property (@(posedge clk) disable iff (!rst_n)
    retry |=> !retry);

  // R2, R3: a retry follows a cycle with both commits present
  a_r2_retry_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> $past(a_valid && b_valid));

  // R7: stalled cores never see a retry
  a_r7_hold_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !retry);

  // R7: test mode always stalls
  a_r7_test_holds: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> hold);

  // R7: test mode persists until the test reports
  a_r7_test_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !test_done) |=> test_mode);

  // R9: a lone core runs unchecked and unstalled
  a_r9_solo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(core_en) == 1) |-> (!retry && !hold && !test_mode));

  // R11: fatal keeps the stall and leaves test mode
  a_r11_fatal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |-> (hold && !test_mode));

  // R8: at least one core stays enabled
  a_r8_core_alive: assert property (@(posedge clk) disable iff (!rst_n)
    core_en != 2'b00);

  // R12: status bits never clear outside reset
  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status) & ~status) == 4'b0000);

endmodule

bind lockstep_supervisor lsv_checker u_chk (
  .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .b_valid(b_valid),
  .test_done(test_done), .retry(retry), .hold(hold),
  .test_mode(test_mode), .core_en(core_en), .fatal(fatal), .status(status)
);

// File: tb/sim_lockstep_supervisor.sv
`timescale 1ns/1ps
module sim_lockstep_supervisor;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_valid, b_valid, a_swe, b_swe;
  logic [31:0] a_wdata, b_wdata, a_saddr, b_saddr, a_sdata, b_sdata;
  logic [4:0]  a_wdst, b_wdst;
  logic [31:0] commit_pc;
  logic [3:0]  perm_limit;
  logic        test_done, test_pass_a, test_pass_b;
  logic        retry, hold, test_mode, fatal;
  logic [31:0] retry_pc;
  logic [1:0]  core_en;
  logic [3:0]  status;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lockstep_supervisor u0 (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_wdata(a_wdata), .a_wdst(a_wdst), .a_swe(a_swe),
    .a_saddr(a_saddr), .a_sdata(a_sdata),
    .b_valid(b_valid), .b_wdata(b_wdata), .b_wdst(b_wdst), .b_swe(b_swe),
    .b_saddr(b_saddr), .b_sdata(b_sdata),
    .commit_pc(commit_pc), .perm_limit(perm_limit),
    .test_done(test_done), .test_pass_a(test_pass_a), .test_pass_b(test_pass_b),
    .retry(retry), .retry_pc(retry_pc), .hold(hold), .test_mode(test_mode),
    .core_en(core_en), .fatal(fatal), .status(status)
  );

  // kind: 0 equal, 1 wdata, 2 dst, 3 store enable, 4 saddr, 5 sdata, 6 saddr with no store
  // entry: {pc[15:0], kind[3:0], expect_retry}
  localparam logic [20:0] VEC [10] = '{
    {16'h0010, 4'd0, 1'b0},
    {16'h0010, 4'd1, 1'b1},
    {16'h0020, 4'd2, 1'b1},
    {16'h0020, 4'd0, 1'b0},
    {16'h0020, 4'd3, 1'b1},
    {16'h0030, 4'd4, 1'b1},
    {16'h0030, 4'd6, 1'b0},
    {16'h0040, 4'd5, 1'b1},
    {16'h0040, 4'd5, 1'b1},
    {16'h0044, 4'd0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    a_valid = 1'b0; b_valid = 1'b0; test_done = 1'b0;
  endtask

  task automatic put(input logic [31:0] pc, input int kind, input logic va, input logic vb);
    commit_pc = pc;
    a_valid = va; b_valid = vb;
    a_wdata = pc * 32'd7 + 32'd1; b_wdata = a_wdata;
    a_wdst  = pc[4:0];            b_wdst  = a_wdst;
    a_swe   = (kind == 0) || (kind == 4) || (kind == 5); b_swe = a_swe;
    a_saddr = pc + 32'd100;       b_saddr = a_saddr;
    a_sdata = pc ^ 32'hFFFF;      b_sdata = a_sdata;
    case (kind)
      1: b_wdata = a_wdata ^ 32'h1;
      2: b_wdst  = a_wdst ^ 5'h4;
      3: begin a_swe = 1'b1; b_swe = 1'b0; end
      4: b_saddr = a_saddr ^ 32'h80;
      5: b_sdata = a_sdata ^ 32'h8000_0000;
      6: b_saddr = a_saddr ^ 32'h10;
      default: ;
    endcase
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic verdict(input logic pa, input logic pb);
    test_done = 1'b1; test_pass_a = pa; test_pass_b = pb;
    step();
    test_done = 1'b0; test_pass_a = 1'b0; test_pass_b = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; perm_limit = 4'd3;
    test_pass_a = 1'b0; test_pass_b = 1'b0;
    put(32'h0, 0, 1'b0, 1'b0);
    idle();
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 core_en", {30'd0, core_en}, 32'h3);
    chk("R1 hold", {31'd0, hold}, 0);
    chk("R1 test_mode", {31'd0, test_mode}, 0);
    chk("R1 retry", {31'd0, retry}, 0);
    chk("R1 fatal", {31'd0, fatal}, 0);
    chk("R1 status", {28'd0, status}, 0);

    // R3 R5 table walk, limit 3
    for (int i = 0; i < 10; i++) begin
      put({16'd0, VEC[i][20:5]}, int'(VEC[i][4:1]), 1'b1, 1'b1);
      step();
      chk("R3 retry", {31'd0, retry}, {31'd0, VEC[i][0]});
      if (VEC[i][0]) chk("R3 retry_pc", retry_pc, {16'd0, VEC[i][20:5]});
      chk("R5 no hold under limit", {31'd0, hold}, 0);
      idle();
      step();
      chk("R3 retry one cycle", {31'd0, retry}, 0);
    end

    // R2 single-core commit ignored
    put(32'h48, 1, 1'b1, 1'b0); step();
    chk("R2 only A valid", {31'd0, retry}, 0);
    put(32'h48, 1, 1'b0, 1'b1); step();
    chk("R2 only B valid", {31'd0, retry}, 0);
    idle(); step();

    // R4 commits during retry cycle ignored
    put(32'h4C, 1, 1'b1, 1'b1); step();
    chk("R4 first retry", {31'd0, retry}, 1);
    put(32'h4C, 2, 1'b1, 1'b1); step();
    chk("R4 retry cycle commit ignored", {31'd0, retry}, 0);
    idle(); step();
    chk("R4 still no retry", {31'd0, retry}, 0);

    // R5 R7 permanent fault, limit 2 at pc 0x50
    perm_limit = 4'd2;
    for (int k = 0; k < 2; k++) begin
      put(32'h50, 1, 1'b1, 1'b1); step();
      chk("R5 repeat under limit retries", {31'd0, retry}, 1);
      idle(); step();
    end
    put(32'h50, 1, 1'b1, 1'b1); step();
    chk("R7 perm no retry", {31'd0, retry}, 0);
    chk("R7 hold", {31'd0, hold}, 1);
    chk("R7 test_mode", {31'd0, test_mode}, 1);
    chk("R7 status perm", {28'd0, status}, 32'h8);
    step(); step();
    chk("R7 hold persists", {31'd0, hold}, 1);
    chk("R7 no retry in test", {31'd0, retry}, 0);
    idle();

    // R8 B fails
    verdict(1'b1, 1'b0);
    chk("R8 core_en A only", {30'd0, core_en}, 32'h1);
    chk("R8 hold released", {31'd0, hold}, 0);
    chk("R8 test_mode off", {31'd0, test_mode}, 0);
    chk("R8 status B removed", {28'd0, status}, 32'hA);
    // R9 solo ignores differences
    put(32'h54, 1, 1'b1, 1'b1); step();
    chk("R9 solo no retry", {31'd0, retry}, 0);
    chk("R9 solo no hold", {31'd0, hold}, 0);
    idle(); step();
    // R12 test_done after solo leaves status alone
    verdict(1'b0, 1'b0);
    chk("R12 status sticky", {28'd0, status}, 32'hA);

    // R8 A fails
    do_reset();
    chk("R12 reset clears status", {28'd0, status}, 0);
    perm_limit = 4'd0;
    put(32'h58, 5, 1'b1, 1'b1); step();
    chk("R5 limit 0 escalates at once", {31'd0, hold}, 1);
    idle();
    verdict(1'b0, 1'b1);
    chk("R8 core_en B only", {30'd0, core_en}, 32'h2);
    chk("R8 status A removed", {28'd0, status}, 32'h9);

    // R11 both fail
    do_reset();
    perm_limit = 4'd0;
    put(32'h5C, 2, 1'b1, 1'b1); step();
    idle(); step();
    verdict(1'b0, 1'b0);
    chk("R11 fatal", {31'd0, fatal}, 1);
    chk("R11 hold kept", {31'd0, hold}, 1);
    chk("R11 test_mode off", {31'd0, test_mode}, 0);
    chk("R11 status", {28'd0, status}, 32'hC);
    verdict(1'b1, 1'b1);
    chk("R11 done ignored", {31'd0, hold}, 1);

    // R10 both pass, tracker cleared
    do_reset();
    perm_limit = 4'd1;
    put(32'h60, 1, 1'b1, 1'b1); step();
    chk("R10 first retry", {31'd0, retry}, 1);
    idle(); step();
    put(32'h60, 1, 1'b1, 1'b1); step();
    chk("R10 escalate", {31'd0, test_mode}, 1);
    idle();
    verdict(1'b1, 1'b1);
    chk("R10 core_en", {30'd0, core_en}, 32'h3);
    chk("R10 hold off", {31'd0, hold}, 0);
    chk("R10 status", {28'd0, status}, 32'h8);
    put(32'h60, 1, 1'b1, 1'b1); step();
    chk("R10 count restarted", {31'd0, retry}, 1);
    chk("R10 no hold", {31'd0, hold}, 0);
    idle(); step();

    // R6 saturation with limit 15
    perm_limit = 4'd15;
    for (int k = 0; k < 20; k++) begin
      put(32'h70, 4, 1'b1, 1'b1); step();
      chk("R6 saturated retry", {31'd0, retry}, 1);
      chk("R6 never hold", {31'd0, hold}, 0);
      idle(); step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule